// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block combines the four legacy wire interrupts (INTA through INTD) and inbound message-signalled interrupt (MSI) writes into one interrupt line for the host CPU. The legacy inputs are latched into a status register whose bits software clears by writing 1. A separate enable register selects which status bits may raise the output.

Inbound MSI writes come in on a simple valid/address/data port. A write is taken only when MSI capture is switched on and its 64-bit address falls inside a programmed window. Each write that is taken sets a summary status bit and places its data and address in a small queue. Software checks a pending bit, reads the head address, and then reads the data register. That read removes the entry from the queue. Software repeats this until the pending bit clears.

Register access uses a single-cycle port. Writes take effect at the clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After synchronous active-low reset, every register reads 0 and `irq_out` is low. The registers are: enable 0x00, status 0x04, window base low 0x10, window base high 0x14, window size 0x18, MSI on 0x1C, pending 0x20, data 0x24, head address low 0x28, head address high 0x2C.
- R2: Each cycle in which `intx_in[i]` is high sets status bit 5+i, so INTA is bit 5 and INTD is bit 8. While the input stays high, the bit stays set even if it is cleared in the same cycle.
- R3: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: `irq_out` is high exactly when (status & enable) is nonzero. A bit that is set but not enabled stays visible in status and does not raise `irq_out`.
- R5: An MSI write is ignored when bit 0 of the MSI-on register is 0, or when its address lies outside [base, base+size), where base is {base high, base low}. An ignored write changes neither the status register nor the pending register.
- R6: A write that is taken sets status bit 3 and pending bit 0. Both are visible in the cycle after the write.
- R7: The head address registers show the oldest queued entry and do not remove it. Reading the data register returns the oldest entry's data and removes that entry. Entries leave in the order they arrived.
- R8: Pending bit 0 clears once the last queued entry has been removed.
- R9: The queue holds 16 entries. A write that is taken while the queue is full is dropped and sets pending bit 1. Bit 1 stays set until software writes 1 to pending bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_in | input | 4 | Legacy interrupts INTA..INTD, level or pulse |
| msi_valid | input | 1 | Inbound MSI write strobe |
| msi_addr | input | 64 | Inbound MSI write address |
| msi_data | input | 32 | Inbound MSI write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the data register removes the head entry) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The legacy path is driven three ways: with one-cycle pulses, with a level held across a clear, and with enable bits off. These show apart latching, set-over-clear priority and output masking. MSI addresses are sent one below the base, exactly at the base, at the last word of the window and exactly at base+size, first with capture off and then on. This pins each window edge and the on/off gate. A burst of seventeen writes into a sixteen-entry queue, drained one entry at a time, checks order, the non-removing head view, drop on full and the sticky overflow bit with its clear.

// File: rtl/irqagg_pkg.sv
// Shared constants and types for the interrupt aggregator.
// Assumes 64-bit MSI addresses and 32-bit message data.
package irqagg_pkg;
    localparam int MSG_AW      = 64;
    localparam int MSG_DW      = 32;
    localparam int SIZE_W      = 32;
    localparam int NUM_INTX    = 4;
    localparam int INTX_LSB    = 5;
    localparam int MSI_SUM_BIT = 3;
    localparam int REG_AW      = 8;
    localparam int REG_DW      = 32;

    localparam logic [REG_AW-1:0] OFS_ENABLE  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_BASE_LO = 8'h10;
    localparam logic [REG_AW-1:0] OFS_BASE_HI = 8'h14;
    localparam logic [REG_AW-1:0] OFS_SIZE    = 8'h18;
    localparam logic [REG_AW-1:0] OFS_MSI_ON  = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_PEND    = 8'h20;
    localparam logic [REG_AW-1:0] OFS_DATA    = 8'h24;
    localparam logic [REG_AW-1:0] OFS_HEAD_LO = 8'h28;
    localparam logic [REG_AW-1:0] OFS_HEAD_HI = 8'h2C;

    typedef struct packed {
        logic [MSG_AW-1:0] addr;
        logic [MSG_DW-1:0] data;
    } msi_rec_t;
endpackage

// File: rtl/irqagg_window.sv
// Address window match for inbound MSI writes.
// Decides whether an address lies in [base, base+size) while capture is on.
// Assumes size is at most 2^SIZE_W-1 bytes; the comparison cannot wrap.
module irqagg_window
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_on,
    input  logic [MSG_AW-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic [MSG_AW-1:0] addr,
    output logic              hit
);
    logic [MSG_AW:0] offs;

    // Subtract with a borrow bit; the write is in range if there is no borrow and offset < size.
    always_comb begin
        offs = {1'b0, addr} - {1'b0, base};
        hit  = win_on && !offs[MSG_AW] &&
               (offs[MSG_AW-1:0] < {{(MSG_AW-SIZE_W){1'b0}}, size});
    end

    AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < base) |-> !hit);                                   // R5
endmodule

// File: rtl/irqagg_queue.sv
// FIFO for captured MSI records.
// Pushes are refused when full; pops are ignored when empty. Storage has no reset.
module irqagg_queue
    import irqagg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  msi_rec_t din,
    input  logic     pop,
    output msi_rec_t head,
    output logic     full,
    output logic     empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    msi_rec_t        mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Write the incoming record into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Advance the pointers (wrapping at DEPTH) and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt == $past(cnt)));           // R9
    AST_FIFO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (cnt == $past(cnt) + CW'(1))); // R7
endmodule

// File: rtl/pcie_irq_aggregator.sv
// Merges legacy INTx and captured MSI writes into one interrupt line.
// Holds the enable/status registers, the MSI window setup and the pending/overflow flags.
// Assumes a single-cycle register port; read data is combinational.
module pcie_irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int QDEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INTX-1:0] intx_in,
    input  logic                msi_valid,
    input  logic [MSG_AW-1:0]   msi_addr,
    input  logic [MSG_DW-1:0]   msi_data,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    output logic                irq_out
);
    localparam logic [REG_DW-1:0] STAT_MASK =
        (REG_DW'(1) << MSI_SUM_BIT) |
        (((REG_DW'(1) << NUM_INTX) - REG_DW'(1)) << INTX_LSB);

    logic [REG_DW-1:0] en_q, stat_q, stat_d;
    logic [MSG_AW-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic              msi_on_q, ovf_q;
    logic              hit, accept, q_full, q_empty, pop_req;
    logic              wr_stat;
    msi_rec_t          q_head, q_din;

    assign wr_stat = reg_wr && (reg_addr == OFS_STATUS);
    assign accept  = msi_valid && hit;
    assign pop_req = reg_rd && (reg_addr == OFS_DATA);
    assign q_din   = '{addr: msi_addr, data: msi_data};
    assign irq_out = |(stat_q & en_q);

    irqagg_window win_i (
        .clk(clk), .rst_n(rst_n), .win_on(msi_on_q), .base(base_q),
        .size(size_q), .addr(msi_addr), .hit(hit)
    );

    irqagg_queue #(.DEPTH(QDEPTH)) queue_i (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(q_din), .pop(pop_req),
        .head(q_head), .full(q_full), .empty(q_empty)
    );

    // Next status: clear written-one bits first, then new events set bits (set wins).
    always_comb begin
        stat_d = stat_q;
        if (wr_stat) stat_d = stat_d & ~reg_wdata;
        stat_d[INTX_LSB +: NUM_INTX] = stat_d[INTX_LSB +: NUM_INTX] | intx_in;
        if (accept) stat_d[MSI_SUM_BIT] = 1'b1;
        stat_d = stat_d & STAT_MASK;
    end

    // Hold the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            base_q   <= '0;
            size_q   <= '0;
            msi_on_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_ENABLE:  en_q           <= reg_wdata & STAT_MASK;
                OFS_BASE_LO: base_q[31:0]   <= reg_wdata;
                OFS_BASE_HI: base_q[63:32]  <= reg_wdata;
                OFS_SIZE:    size_q         <= reg_wdata;
                OFS_MSI_ON:  msi_on_q       <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Sticky overflow flag: set by a drop, cleared by writing 1 to pending bit 1 (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_q <= 1'b0;
        else if (accept && q_full)  ovf_q <= 1'b1;
        else if (reg_wr && reg_addr == OFS_PEND && reg_wdata[1]) ovf_q <= 1'b0;
    end

    // Read multiplexer; queue views read 0 when the queue is empty.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_ENABLE:  reg_rdata = en_q;
                OFS_STATUS:  reg_rdata = stat_q;
                OFS_BASE_LO: reg_rdata = base_q[31:0];
                OFS_BASE_HI: reg_rdata = base_q[63:32];
                OFS_SIZE:    reg_rdata = size_q;
                OFS_MSI_ON:  reg_rdata = {{(REG_DW-1){1'b0}}, msi_on_q};
                OFS_PEND:    reg_rdata = {{(REG_DW-2){1'b0}}, ovf_q, !q_empty};
                OFS_DATA:    reg_rdata = q_empty ? '0 : q_head.data;
                OFS_HEAD_LO: reg_rdata = q_empty ? '0 : q_head.addr[31:0];
                OFS_HEAD_HI: reg_rdata = q_empty ? '0 : q_head.addr[63:32];
                default: ;
            endcase
        end
    end

    genvar gi;
    for (gi = 0; gi < NUM_INTX; gi++) begin : g_intx_chk
        AST_INTX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            intx_in[gi] |=> stat_q[INTX_LSB+gi]);                     // R2
    end

    AST_W1C_MSI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[MSI_SUM_BIT] && !msi_valid) |=> !stat_q[MSI_SUM_BIT]); // R3
    AST_IGNORED_MSI: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !hit && !wr_stat) |=> $stable(stat_q[MSI_SUM_BIT]));            // R5
    AST_PEND_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !q_full) |=> !q_empty);                                            // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q != '0));                                                    // R4
endmodule

// File: tb/pcie_irq_aggregator_tb_top.sv
module pcie_irq_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_BLO = 8'h10, A_BHI = 8'h14,
                           A_SZ = 8'h18, A_ON = 8'h1C, A_PD = 8'h20, A_DT = 8'h24,
                           A_HLO = 8'h28, A_HHI = 8'h2C;
    localparam logic [63:0] WBASE = 64'h0000_0001_0000_2000;
    localparam logic [31:0] WSIZE = 32'd4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_in = '0;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .msi_valid(msi_valid),
        .msi_addr(msi_addr), .msi_data(msi_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_intx(input logic [3:0] v);
        @(negedge clk);
        intx_in = v;
        @(negedge clk);
        intx_in = '0;
    endtask

    task automatic send_msi(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_ST, v);  chk("R1 status", v, 32'h0);
        rd(A_EN, v);  chk("R1 enable", v, 32'h0);
        rd(A_PD, v);  chk("R1 pending", v, 32'h0);
        rd(A_SZ, v);  chk("R1 size", v, 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_intx();
        logic [31:0] v;
        wr(A_EN, 32'h1E8);
        rd(A_EN, v); chk("R4 enable readback", v, 32'h1E8);
        pulse_intx(4'b0001);
        rd(A_ST, v); chk("R2 INTA pulse bit5", v, 32'h20);
        chk("R4 irq on enabled bit", 32'(irq_out), 32'h1);
        pulse_intx(4'b0010);
        wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R3 write 0 keeps bits", v, 32'h60);
        wr(A_ST, 32'h20);
        rd(A_ST, v); chk("R3 W1C one bit", v, 32'h40);
        wr(A_ST, 32'h40);
        rd(A_ST, v); chk("R3 W1C last bit", v, 32'h0);
        chk("R4 irq low after clear", 32'(irq_out), 32'h0);
        @(negedge clk); intx_in = 4'b0100;
        wr(A_ST, 32'h80);
        rd(A_ST, v); chk("R2 level wins over clear", v, 32'h80);
        @(negedge clk); intx_in = '0;
        wr(A_ST, 32'h80);
        rd(A_ST, v); chk("R2 cleared after release", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_EN, 32'h0);
        pulse_intx(4'b1000);
        rd(A_ST, v); chk("R4 masked bit8 visible", v, 32'h100);
        chk("R4 masked no irq", 32'(irq_out), 32'h0);
        wr(A_EN, 32'h100);
        chk("R4 irq after enable", 32'(irq_out), 32'h1);
        wr(A_ST, 32'h100);
        chk("R4 irq after clear", 32'(irq_out), 32'h0);
    endtask

    task automatic t_window();
        logic [31:0] v;
        wr(A_BLO, WBASE[31:0]);
        wr(A_BHI, WBASE[63:32]);
        wr(A_SZ, WSIZE);
        wr(A_EN, 32'h8);
        send_msi(WBASE, 32'h55);
        rd(A_PD, v); chk("R5 capture off pending", v, 32'h0);
        rd(A_ST, v); chk("R5 capture off status", v, 32'h0);
        wr(A_ON, 32'h1);
        send_msi(WBASE - 64'd4, 32'h66);
        send_msi(WBASE + 64'(WSIZE), 32'h77);
        rd(A_PD, v); chk("R5 outside window pending", v, 32'h0);
        rd(A_ST, v); chk("R5 outside window status", v, 32'h0);
        chk("R5 outside window irq", 32'(irq_out), 32'h0);
        send_msi(WBASE, 32'hA1);
        rd(A_PD, v); chk("R6 pending set", v, 32'h1);
        rd(A_ST, v); chk("R6 status bit3", v, 32'h8);
        chk("R6 irq", 32'(irq_out), 32'h1);
        send_msi(WBASE + 64'(WSIZE) - 64'd4, 32'hA2);
        rd(A_HLO, v); chk("R7 head lo", v, WBASE[31:0]);
        rd(A_HHI, v); chk("R7 head hi", v, WBASE[63:32]);
        rd(A_HLO, v); chk("R7 head read keeps entry", v, WBASE[31:0]);
        rd(A_DT, v);  chk("R7 first data", v, 32'hA1);
        rd(A_HLO, v); chk("R7 next head lo", v, WBASE[31:0] + WSIZE - 32'd4);
        rd(A_PD, v);  chk("R8 still pending", v, 32'h1);
        rd(A_DT, v);  chk("R7 second data", v, 32'hA2);
        rd(A_PD, v);  chk("R8 pending clear", v, 32'h0);
        wr(A_ST, 32'h8);
        chk("R3 MSI summary cleared irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 17; i++) send_msi(WBASE + 64'(i*4), 32'h100 + 32'(i));
        rd(A_PD, v); chk("R9 overflow and pending", v, 32'h3);
        for (int i = 0; i < 16; i++) begin
            rd(A_DT, v); chk("R9 drained order", v, 32'h100 + 32'(i));
        end
        rd(A_PD, v); chk("R9 overflow sticky after drain", v, 32'h2);
        wr(A_PD, 32'h0);
        rd(A_PD, v); chk("R9 write 0 keeps overflow", v, 32'h2);
        wr(A_PD, 32'h2);
        rd(A_PD, v); chk("R9 overflow cleared", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_intx();
        t_mask();
        t_window();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule